// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the timing strobes of an asynchronous serial controller from the bus clock. The bus clock runs at one quarter of the core clock and arrives here as a one-cycle enable, `bus_ce`. An 8-bit rate register holds two fields that set the division. A 2-bit prescale code picks a fixed ratio of 1, 3, 4 or 13, and a 3-bit exponent adds a further division by 2^n. The combined ratio P = ratio × 2^n, from 1 to 1664, sets the rate of the oversampling strobe `os_tick`, which is the bus rate divided by P. The data bit strobe `bit_tick` is that rate divided by sixteen. With the boot value 0x33 and a 2 MHz bus, P = 104 and the bit rate comes to roughly 1200 baud.

The register has one write port. Every write stores the byte and restarts all three counters: the prescaler, the power-of-two stage and the sixteen-step oversampling counter. The three remaining bits are test bits. They are stored and can be read back, but they do not change the division. A small sequencer has two states. `ST_ARM` holds the counters at zero for one cycle. The sequencer enters it on reset and on every write (transition *restart*), and always moves on to `ST_RUN` in the next cycle (transition *arm_done*). In `ST_RUN` each `bus_ce` pulse advances the chain, and the sequencer stays there until the next write. On reset the register takes 0x33 when `boot_mode` is high and 0x00 otherwise.

Top module: `sci_baud_gen`

## Requirements
- R1: While `rst` is high and `boot_mode` is low, the register is cleared, so `baud_q` reads 0x00 after reset. Neither strobe is high during reset.
- R2: When `boot_mode` is high during reset, `baud_q` reads 0x33 after reset. The first `os_tick` comes on the 104th `bus_ce` pulse after the arm cycle.
- R3: The prescale code in `baud_q[5:4]` selects the ratio: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R4: The exponent n in `baud_q[2:0]` multiplies the ratio by 2^n, so P = ratio × 2^n.
- R5: `os_tick` is high for exactly the cycles in which `bus_ce` is high and that pulse is a multiple of P, counting `bus_ce` pulses from the first `ST_RUN` cycle.
- R6: `bit_tick` is high only together with `os_tick`, on every sixteenth `os_tick` (pulse counts that are multiples of 16·P).
- R7: A write restarts the counting. `bus_ce` is ignored in the write cycle and in the following arm cycle, no strobe fires in either cycle, and the first `os_tick` comes P pulses later.
- R8: Bits 7, 6 and 3 are stored and read back on `baud_q`. They have no effect on the strobe timing.
- R9: A write makes `baud_q` equal to `baud_wdata` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_mode | input | 1 | Selects the 0x33 reset value of the rate register |
| bus_ce | input | 1 | One-cycle bus clock enable |
| baud_wr | input | 1 | Write strobe for the rate register |
| baud_wdata | input | 8 | Write data |
| baud_q | output | 8 | Current rate register value |
| os_tick | output | 1 | Oversampling strobe, one cycle |
| bit_tick | output | 1 | Bit strobe, one cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 3-bit exponent and a factor of sixteen. Most scenarios drive `bus_ce` high on every cycle, which keeps even the largest ratio of 1664 within reach. At that ratio a full bit period is 26,624 pulses, so the bench can see the first `bit_tick` at the slowest setting. The prescale sweep spaces `bus_ce` one cycle in four, the same spacing as the core-to-bus ratio. This checks that only enabled cycles count. Extra cases cover a rewrite in the middle of a period with `bus_ce` high in the write and arm cycles, and writes that carry the test bits.

// File: rtl/sci_baud_pkg.sv
package sci_baud_pkg;

    typedef enum logic [0:0] {
        ST_ARM = 1'b0,
        ST_RUN = 1'b1
    } gen_state_e;

    localparam int PRE_CNT_W = 4;

    // Terminal count (ratio minus one) for each prescale code.
    function automatic logic [PRE_CNT_W-1:0] prescale_last(input logic [1:0] code);
        logic [PRE_CNT_W-1:0] r;
        unique case (code)
            2'b00:   r = PRE_CNT_W'(0);
            2'b01:   r = PRE_CNT_W'(2);
            2'b10:   r = PRE_CNT_W'(3);
            default: r = PRE_CNT_W'(12);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] last,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = step && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (clear)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_pow2_stage.sv
module baud_pow2_stage #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             wrap
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // A thermometer mask of sel ones gives the terminal count 2^sel - 1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    assign wrap = step && (cnt_q == mask);

    always_ff @(posedge clk) begin
        if (clear)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_os_counter.sv
module baud_os_counter #(
    parameter int FACTOR = 16
) (
    input  logic clk,
    input  logic clear,
    input  logic step,
    output logic wrap
);
    localparam int W = (FACTOR > 1) ? $clog2(FACTOR) : 1;

    logic [W-1:0] cnt_q;

    assign wrap = step && (cnt_q == W'(FACTOR - 1));

    always_ff @(posedge clk) begin
        if (clear)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sci_baud_gen.sv
module sci_baud_gen
    import sci_baud_pkg::*;
#(
    parameter int                 REG_W      = 8,
    parameter int                 PRE_LSB    = 4,
    parameter int                 SEL_LSB    = 0,
    parameter int                 SEL_W      = 3,
    parameter int                 OS_FACTOR  = 16,
    parameter logic [REG_W-1:0]   BOOT_VALUE = 8'h33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_mode,
    input  logic             bus_ce,
    input  logic             baud_wr,
    input  logic [REG_W-1:0] baud_wdata,
    output logic [REG_W-1:0] baud_q,
    output logic             os_tick,
    output logic             bit_tick
);
    gen_state_e state_q, state_d;

    logic [REG_W-1:0]     reg_q;
    logic                 clear;
    logic                 step;
    logic                 pre_wrap;
    logic                 pow_wrap;
    logic                 os_wrap;
    logic [1:0]           pre_code;
    logic [SEL_W-1:0]     sel;

    // Rate register
    always_ff @(posedge clk) begin
        if (rst)
            reg_q <= boot_mode ? BOOT_VALUE : '0;
        else if (baud_wr)
            reg_q <= baud_wdata;
    end

    assign baud_q   = reg_q;
    assign pre_code = reg_q[PRE_LSB +: 2];
    assign sel      = reg_q[SEL_LSB +: SEL_W];

    // Sequencer: state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_ARM;
        else
            state_q <= state_d;
    end

    // Sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:  state_d = ST_RUN;                        // arm_done
            ST_RUN:  state_d = baud_wr ? ST_ARM : ST_RUN;     // restart
            default: state_d = ST_ARM;
        endcase
        if (baud_wr)
            state_d = ST_ARM;                                 // restart
    end

    // Sequencer: counter control
    always_comb begin
        clear = 1'b1;
        step  = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                clear = 1'b1;
                step  = 1'b0;
            end
            ST_RUN: begin
                clear = rst || baud_wr;
                step  = bus_ce && !rst && !baud_wr;
            end
            default: begin
                clear = 1'b1;
                step  = 1'b0;
            end
        endcase
    end

    baud_prescaler #(.CNT_W(PRE_CNT_W)) u_pre (
        .clk   (clk),
        .clear (clear),
        .step  (step),
        .last  (prescale_last(pre_code)),
        .wrap  (pre_wrap)
    );

    baud_pow2_stage #(.SEL_W(SEL_W)) u_pow (
        .clk   (clk),
        .clear (clear),
        .step  (pre_wrap),
        .sel   (sel),
        .wrap  (pow_wrap)
    );

    baud_os_counter #(.FACTOR(OS_FACTOR)) u_os (
        .clk   (clk),
        .clear (clear),
        .step  (pow_wrap),
        .wrap  (os_wrap)
    );

    // Outputs
    always_comb begin
        os_tick  = pow_wrap;
        bit_tick = os_wrap;
    end
endmodule

// File: rtl/sci_baud_gen_chk.sv
module sci_baud_gen_chk #(
    parameter int REG_W     = 8,
    parameter int OS_FACTOR = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_ce,
    input logic             baud_wr,
    input logic [REG_W-1:0] baud_wdata,
    input logic [REG_W-1:0] baud_q,
    input logic             os_tick,
    input logic             bit_tick
);
    localparam int CW = $clog2(OS_FACTOR) + 1;

    logic [CW-1:0] os_seen;

    always_ff @(posedge clk) begin
        if (rst || baud_wr || bit_tick)
            os_seen <= '0;
        else if (os_tick)
            os_seen <= os_seen + 1'b1;
    end

    assert_os_on_enable_R5: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> bus_ce);

    assert_bit_with_os_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);

    assert_bit_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (os_seen == CW'(OS_FACTOR - 1)));

    assert_quiet_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        baud_wr |-> (!os_tick && !bit_tick));

    assert_quiet_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        baud_wr |=> !os_tick);

    assert_reg_load_R9: assert property (@(posedge clk) disable iff (rst)
        baud_wr |=> (baud_q == $past(baud_wdata)));
endmodule

bind sci_baud_gen sci_baud_gen_chk #(.REG_W(REG_W), .OS_FACTOR(OS_FACTOR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_ce     (bus_ce),
    .baud_wr    (baud_wr),
    .baud_wdata (baud_wdata),
    .baud_q     (baud_q),
    .os_tick    (os_tick),
    .bit_tick   (bit_tick)
);

// File: tb/sim_sci_baud_gen.sv
`timescale 1ns/1ps
module sim_sci_baud_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_mode = 1'b0;
    logic       bus_ce = 1'b0;
    logic       baud_wr = 1'b0;
    logic [7:0] baud_wdata = 8'h00;
    logic [7:0] baud_q;
    logic       os_tick;
    logic       bit_tick;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sci_baud_gen u0 (
        .clk(clk), .rst(rst), .boot_mode(boot_mode), .bus_ce(bus_ce),
        .baud_wr(baud_wr), .baud_wdata(baud_wdata), .baud_q(baud_q),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive bus_ce pulses (each preceded by gap idle cycles) and check strobes.
    task automatic run_ticks(input string req, input int p, input int ticks, input int gap);
        int bad_os = 0, bad_bit = 0, os_at = -1, bit_at = -1;
        int os_act = 0, os_exp = 0, bit_act = 0, bit_exp = 0;
        for (int k = 1; k <= ticks; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); bus_ce = 1'b0; #1;
                if (os_tick || bit_tick) begin
                    if (bad_os == 0) begin os_at = k; os_act = 1; os_exp = 0; end
                    bad_os++;
                end
            end
            @(negedge clk); bus_ce = 1'b1; #1;
            if (os_tick !== ((k % p) == 0)) begin
                if (bad_os == 0) begin os_at = k; os_act = os_tick; os_exp = ((k % p) == 0); end
                bad_os++;
            end
            if (bit_tick !== ((k % (16 * p)) == 0)) begin
                if (bad_bit == 0) begin bit_at = k; bit_act = bit_tick; bit_exp = ((k % (16 * p)) == 0); end
                bad_bit++;
            end
        end
        @(negedge clk); bus_ce = 1'b0;
        check(bad_os == 0, req, $sformatf("os_tick at pulse %0d (P=%0d)", os_at, p), os_act, os_exp);
        check(bad_bit == 0, "R6", $sformatf("bit_tick at pulse %0d (P=%0d)", bit_at, p), bit_act, bit_exp);
    endtask

    // Write the register; bus_ce in the write and arm cycles is ce_arm.
    task automatic write_reg(input logic [7:0] v, input bit ce_arm);
        @(negedge clk); baud_wr = 1'b1; baud_wdata = v; bus_ce = ce_arm; #1;
        check(!os_tick && !bit_tick, "R7", "strobe in write cycle", os_tick, 0);
        @(negedge clk); baud_wr = 1'b0; bus_ce = ce_arm; #1;
        check(!os_tick && !bit_tick, "R7", "strobe in arm cycle", os_tick, 0);
        check(baud_q == v, "R9", "register readback", baud_q, v);
    endtask

    task automatic do_reset(input bit boot);
        @(negedge clk); rst = 1'b1; boot_mode = boot; bus_ce = 1'b1; #1;
        @(negedge clk); #1;
        check(!os_tick && !bit_tick, "R1", "strobe during reset", os_tick, 0);
        @(negedge clk); rst = 1'b0; bus_ce = 1'b0; #1;   // arm cycle
        check(!os_tick, "R1", "strobe in arm cycle after reset", os_tick, 0);
    endtask

    task automatic t_reset_default();
        do_reset(1'b0);
        check(baud_q == 8'h00, "R1", "reset value", baud_q, 0);
        run_ticks("R5", 1, 40, 0);
    endtask

    task automatic t_boot();
        do_reset(1'b1);
        check(baud_q == 8'h33, "R2", "boot reset value", baud_q, 8'h33);
        run_ticks("R2", 104, 16 * 104 + 2, 0);
    endtask

    task automatic t_prescale_sweep();
        int ratio [4] = '{1, 3, 4, 13};
        for (int c = 0; c < 4; c++) begin
            write_reg(8'(c << 4), 1'b0);
            run_ticks("R3", ratio[c], 16 * ratio[c] + 3, 3);
        end
    endtask

    task automatic t_rate_sweep();
        for (int n = 0; n < 8; n++) begin
            write_reg(8'(8'h10 | n), 1'b0);
            run_ticks("R4", 3 << n, 16 * (3 << n) + 1, 0);
        end
    endtask

    task automatic t_slowest();
        write_reg(8'h37, 1'b0);
        run_ticks("R4", 1664, 16 * 1664 + 1, 0);
    endtask

    task automatic t_test_bits();
        write_reg(8'hC9, 1'b0);
        check(baud_q == 8'hC9, "R8", "test bits stored", baud_q, 8'hC9);
        run_ticks("R8", 2, 70, 1);
        write_reg(8'hA9, 1'b0);
        check(baud_q == 8'hA9, "R8", "test bits stored", baud_q, 8'hA9);
        run_ticks("R8", 8, 16 * 8 + 2, 0);
    endtask

    task automatic t_restart();
        write_reg(8'h10, 1'b0);
        run_ticks("R7", 3, 20, 0);
        write_reg(8'h10, 1'b1);
        run_ticks("R7", 3, 50, 0);
        write_reg(8'h21, 1'b0);
        run_ticks("R7", 8, 5, 0);
        write_reg(8'h21, 1'b1);
        run_ticks("R7", 8, 16 * 8 + 1, 2);
    endtask

    task automatic t_reset_clears();
        write_reg(8'h25, 1'b0);
        do_reset(1'b0);
        check(baud_q == 8'h00, "R1", "reset clears written value", baud_q, 0);
    endtask

    initial begin
        t_reset_default();
        t_boot();
        t_prescale_sweep();
        t_rate_sweep();
        t_slowest();
        t_test_bits();
        t_restart();
        t_reset_clears();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule